// File: doc/BRIEF.md
# Residue-Channel Constant Multiplier with Signed-Digit Recoding

This block multiplies one operand held in a three-channel residue number system by an integer constant fixed when the design is elaborated. The three channels use the moduli 2^N-1, 2^N and 2^N+1. Each channel works on its own residue with no signal passing between channels, and each produces the product residue for its own modulus. The block is purely combinational.

For each channel the constant is first reduced by that channel's modulus. It is then rewritten, at elaboration, as a sum of powers of two with coefficients in {-1, 0, +1}, with no two neighbouring coefficients nonzero. The product is the modular sum of shifted copies of the operand, one for each nonzero coefficient, with a copy negated where the coefficient is -1. In the 2^N-1 channel a shift is a rotation and a negation is a bitwise inversion. The 2^N channel simply drops the bits above N. The 2^N+1 channel stores each value minus one in N bits. A separate flag marks a true zero, and that flag bypasses the arithmetic.

The block has no states and no transitions: its outputs depend only on the present inputs.

Top module: `rns_csd_cmul`

## Requirements
- R1: `lo_res_o` equals (x * MULT) mod (2^N-1) for every input residue x = `lo_res_i` in 0..2^N-2; it never shows the all-ones code and is 0 whenever x is 0.
- R2: `pw_res_o` equals (x * MULT) mod 2^N for every x = `pw_res_i` in 0..2^N-1.
- R3: With `hi_zero_i` low, the 2^N+1 operand value is v = `hi_dim_i` + 1 (1..2^N). Let p = (v * MULT) mod (2^N+1). When p is nonzero, `hi_zero_o` is 0 and `hi_dim_o` = p-1. When p is 0, `hi_zero_o` is 1 and `hi_dim_o` is 0.
- R4: When `hi_zero_i` is 1 the operand is zero, whatever the bits on `hi_dim_i`: `hi_zero_o` is 1 and `hi_dim_o` is 0.
- R5: Each output pair depends only on its own channel's inputs. Changing one channel's input leaves the outputs of the other two channels unchanged.
- R6: MULT may exceed a channel modulus and is reduced by each modulus separately. A channel whose modulus divides MULT gives a zero product for every input (0 in the 2^N-1 channel; flag 1 and `hi_dim_o` 0 in the 2^N+1 channel).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lo_res_i | input | N | Operand residue modulo 2^N-1 |
| pw_res_i | input | N | Operand residue modulo 2^N |
| hi_dim_i | input | N | Operand modulo 2^N+1, stored as value minus one |
| hi_zero_i | input | 1 | Marks the 2^N+1 operand as zero |
| lo_res_o | output | N | Product residue modulo 2^N-1 |
| pw_res_o | output | N | Product residue modulo 2^N |
| hi_dim_o | output | N | Product modulo 2^N+1, stored as value minus one |
| hi_zero_o | output | 1 | Marks the 2^N+1 product as zero |

## Verification
The assertions are re-evaluated whenever the inputs change. They check that the 2^N-1 output never shows the redundant all-ones zero, that zero inputs give zero products, that the low product bit of the 2^N channel follows from the operand and constant parities, and that a raised zero flag always comes with cleared data bits. Whether each product residue is the correct value can only be shown by the bench's scenarios. These cover a table of hand-worked vectors, exhaustive sweeps for three constant and width choices (one with a constant that is a multiple of two moduli, one that gives zero products from nonzero operands), and a check that the channels do not affect each other.

// File: rtl/rns_csd_pkg.sv
package rns_csd_pkg;

    // Signed-digit recoding with no adjacent nonzero digits.
    // A digit at bit i has weight +2^i (plus mask) or -2^i (minus mask).
    function automatic logic [31:0] csd_plus(input logic [31:0] c);
        logic [31:0] half;
        logic [31:0] three_half;
        logic [31:0] diff;
        half       = c >> 1;
        three_half = c + half;
        diff       = half ^ three_half;
        return three_half & diff;
    endfunction

    function automatic logic [31:0] csd_minus(input logic [31:0] c);
        logic [31:0] half;
        logic [31:0] three_half;
        logic [31:0] diff;
        half       = c >> 1;
        three_half = c + half;
        diff       = half ^ three_half;
        return half & diff;
    endfunction

endpackage

// File: rtl/rns_chan_lo.sv
module rns_chan_lo #(
    parameter int N = 4,
    parameter int unsigned MULT = 23
) (
    input  logic [N-1:0] x_i,
    output logic [N-1:0] p_o
);
    localparam int unsigned MOD  = (32'd1 << N) - 32'd1;
    localparam int unsigned CRED = MULT % MOD;
    localparam int          P    = N + 2;
    localparam logic [31:0] DPOS = rns_csd_pkg::csd_plus(CRED);
    localparam logic [31:0] DNEG = rns_csd_pkg::csd_minus(CRED);

    function automatic logic [N-1:0] eac_add(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[N-1:0] + {{(N-1){1'b0}}, s[N]};
    endfunction

    logic [2*N-1:0] dbl;
    logic [N-1:0]   acc [0:P];

    assign dbl    = {x_i, x_i};
    assign acc[0] = '0;

    for (genvar i = 0; i < P; i++) begin : g_dig
        localparam int K = i % N;
        logic [N-1:0] term;
        assign term = dbl[N-K +: N];
        if (DPOS[i]) begin : g_pos
            assign acc[i+1] = eac_add(acc[i], term);
        end else if (DNEG[i]) begin : g_neg
            assign acc[i+1] = eac_add(acc[i], ~term);
        end else begin : g_skip
            assign acc[i+1] = acc[i];
        end
    end

    assign p_o = (&acc[P]) ? '0 : acc[P];

    always_comb begin
        AST_LO_NO_ONES: assert (!(&p_o)) else $error("lo channel shows all-ones");      // R1
        AST_LO_ZERO_IN: assert (x_i != '0 || p_o == '0) else $error("lo zero operand"); // R1
    end
endmodule

// File: rtl/rns_chan_pw.sv
module rns_chan_pw #(
    parameter int N = 4,
    parameter int unsigned MULT = 23
) (
    input  logic [N-1:0] x_i,
    output logic [N-1:0] p_o
);
    localparam int unsigned CRED = MULT % (32'd1 << N);
    localparam int          P    = N + 2;
    localparam logic [31:0] DPOS = rns_csd_pkg::csd_plus(CRED);
    localparam logic [31:0] DNEG = rns_csd_pkg::csd_minus(CRED);
    localparam logic [31:0] CVEC = CRED;

    logic [N-1:0] acc [0:P];
    assign acc[0] = '0;

    for (genvar i = 0; i < P; i++) begin : g_dig
        logic [N-1:0] term;
        if (i < N) begin : g_in
            assign term = x_i << i;
        end else begin : g_out
            assign term = '0;
        end
        if (DPOS[i]) begin : g_pos
            assign acc[i+1] = acc[i] + term;
        end else if (DNEG[i]) begin : g_neg
            assign acc[i+1] = acc[i] - term;
        end else begin : g_skip
            assign acc[i+1] = acc[i];
        end
    end

    assign p_o = acc[P];

    always_comb begin
        AST_PW_LSB: assert (p_o[0] == (x_i[0] & CVEC[0])) else $error("pw parity");     // R2
        AST_PW_ZERO_IN: assert (x_i != '0 || p_o == '0) else $error("pw zero operand"); // R2
    end
endmodule

// File: rtl/rns_chan_hi.sv
module rns_chan_hi #(
    parameter int N = 4,
    parameter int unsigned MULT = 23
) (
    input  logic [N-1:0] d_i,
    input  logic         z_i,
    output logic [N-1:0] d_o,
    output logic         z_o
);
    localparam int unsigned MOD  = (32'd1 << N) + 32'd1;
    localparam int unsigned CRED = MULT % MOD;
    localparam int          P    = N + 2;
    localparam logic [31:0] DPOS = rns_csd_pkg::csd_plus(CRED);
    localparam logic [31:0] DNEG = rns_csd_pkg::csd_minus(CRED);

    // times 2^k in value-minus-one form: rotate left, inverting each wrapped bit
    function automatic logic [N-1:0] dim_shift(input logic [N-1:0] d, input int k);
        logic [N-1:0] r;
        r = d;
        for (int j = 0; j < k; j++) r = {r[N-2:0], ~r[N-1]};
        return r;
    endfunction

    // returns {is_zero, sum in value-minus-one form}
    function automatic logic [N:0] dim_add(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N:0] s;
        logic       zr;
        s  = {1'b0, a} + {1'b0, b};
        zr = ~s[N] & (&s[N-1:0]);
        return {zr, s[N-1:0] + {{(N-1){1'b0}}, ~s[N]}};
    endfunction

    logic [N-1:0] acc_d [0:P];
    logic         acc_z [0:P];

    assign acc_d[0] = '0;
    assign acc_z[0] = 1'b1;

    for (genvar i = 0; i < P; i++) begin : g_dig
        if (DPOS[i] || DNEG[i]) begin : g_use
            logic [N-1:0] tv;
            logic [N:0]   sum;
            assign tv  = DPOS[i] ? dim_shift(d_i, i) : ~dim_shift(d_i, i);
            assign sum = dim_add(acc_d[i], tv);
            assign acc_z[i+1] = acc_z[i] ? 1'b0 : sum[N];
            assign acc_d[i+1] = acc_z[i] ? tv : sum[N-1:0];
        end else begin : g_skip
            assign acc_z[i+1] = acc_z[i];
            assign acc_d[i+1] = acc_d[i];
        end
    end

    assign z_o = z_i | acc_z[P];
    assign d_o = z_o ? '0 : acc_d[P];

    always_comb begin
        AST_HI_ZERO_PASS: assert (!z_i || z_o) else $error("hi zero flag lost");          // R4
        AST_HI_ZERO_CLEAN: assert (!z_o || d_o == '0) else $error("hi zero with data");   // R3
    end
endmodule

// File: rtl/rns_csd_cmul.sv
module rns_csd_cmul #(
    parameter int N = 4,
    parameter int unsigned MULT = 23
) (
    input  logic [N-1:0] lo_res_i,
    input  logic [N-1:0] pw_res_i,
    input  logic [N-1:0] hi_dim_i,
    input  logic         hi_zero_i,
    output logic [N-1:0] lo_res_o,
    output logic [N-1:0] pw_res_o,
    output logic [N-1:0] hi_dim_o,
    output logic         hi_zero_o
);
    rns_chan_lo #(.N(N), .MULT(MULT)) u_lo (
        .x_i (lo_res_i),
        .p_o (lo_res_o)
    );

    rns_chan_pw #(.N(N), .MULT(MULT)) u_pw (
        .x_i (pw_res_i),
        .p_o (pw_res_o)
    );

    rns_chan_hi #(.N(N), .MULT(MULT)) u_hi (
        .d_i (hi_dim_i),
        .z_i (hi_zero_i),
        .d_o (hi_dim_o),
        .z_o (hi_zero_o)
    );
endmodule

// File: tb/rns_csd_cmul_test.sv
module rns_csd_cmul_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // instance set 1: N=4, MULT=23
    logic [3:0] a_lo, a_pw, a_hd, a_lo_o, a_pw_o, a_hd_o;
    logic       a_hz, a_hz_o;
    rns_csd_cmul #(.N(4), .MULT(23)) uut (
        .lo_res_i(a_lo), .pw_res_i(a_pw), .hi_dim_i(a_hd), .hi_zero_i(a_hz),
        .lo_res_o(a_lo_o), .pw_res_o(a_pw_o), .hi_dim_o(a_hd_o), .hi_zero_o(a_hz_o));

    // instance set 2: N=6, MULT=10 (13*10 = 2*65 gives a zero product)
    logic [5:0] b_lo, b_pw, b_hd, b_lo_o, b_pw_o, b_hd_o;
    logic       b_hz, b_hz_o;
    rns_csd_cmul #(.N(6), .MULT(10)) uut_b (
        .lo_res_i(b_lo), .pw_res_i(b_pw), .hi_dim_i(b_hd), .hi_zero_i(b_hz),
        .lo_res_o(b_lo_o), .pw_res_o(b_pw_o), .hi_dim_o(b_hd_o), .hi_zero_o(b_hz_o));

    // instance set 3: N=4, MULT=255 = 15*17
    logic [3:0] c_lo, c_pw, c_hd, c_lo_o, c_pw_o, c_hd_o;
    logic       c_hz, c_hz_o;
    rns_csd_cmul #(.N(4), .MULT(255)) uut_c (
        .lo_res_i(c_lo), .pw_res_i(c_pw), .hi_dim_i(c_hd), .hi_zero_i(c_hz),
        .lo_res_o(c_lo_o), .pw_res_o(c_pw_o), .hi_dim_o(c_hd_o), .hi_zero_o(c_hz_o));

    // table for uut: lo in, pw in, hi value, expected lo, pw, hi flag, hi dim
    localparam int NV = 4;
    localparam int TV_LO [0:NV-1] = '{1, 14, 7, 0};
    localparam int TV_PW [0:NV-1] = '{1, 15, 8, 0};
    localparam int TV_HV [0:NV-1] = '{1, 16, 3, 0};
    localparam int EX_LO [0:NV-1] = '{8, 7, 11, 0};
    localparam int EX_PW [0:NV-1] = '{7, 9, 8, 0};
    localparam int EX_HZ [0:NV-1] = '{0, 0, 0, 1};
    localparam int EX_HD [0:NV-1] = '{5, 10, 0, 0};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic exp_hi(input int v, input int mult, input int nb, output int ez, output int ed);
        int m;
        int p;
        m = (1 << nb) + 1;
        p = (v * mult) % m;
        ez = (p == 0) ? 1 : 0;
        ed = (p == 0) ? 0 : p - 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ez;
        int ed;
        a_lo = '0; a_pw = '0; a_hd = '0; a_hz = 1'b1;
        b_lo = '0; b_pw = '0; b_hd = '0; b_hz = 1'b1;
        c_lo = '0; c_pw = '0; c_hd = '0; c_hz = 1'b1;
        @(negedge clk);
        // start state: all-zero operands
        chk("R1 idle lo", a_lo_o, 0);
        chk("R2 idle pw", a_pw_o, 0);
        chk("R4 idle hi flag", a_hz_o, 1);
        chk("R4 idle hi dim", a_hd_o, 0);

        // table of hand-worked vectors
        for (int t = 0; t < NV; t++) begin
            @(posedge clk);
            a_lo = 4'(TV_LO[t]);
            a_pw = 4'(TV_PW[t]);
            a_hz = (TV_HV[t] == 0);
            a_hd = (TV_HV[t] == 0) ? 4'd0 : 4'(TV_HV[t] - 1);
            @(negedge clk);
            chk("R1 table lo", a_lo_o, EX_LO[t]);
            chk("R2 table pw", a_pw_o, EX_PW[t]);
            chk("R3 table hi flag", a_hz_o, EX_HZ[t]);
            chk("R3 table hi dim", a_hd_o, EX_HD[t]);
        end

        // exhaustive, N=4 MULT=23 and MULT=255
        for (int v = 0; v <= 16; v++) begin
            @(posedge clk);
            a_lo = 4'(v % 15); a_pw = 4'(v % 16);
            c_lo = 4'(v % 15); c_pw = 4'(v % 16);
            a_hz = (v == 0); c_hz = (v == 0);
            a_hd = (v == 0) ? 4'b1010 : 4'(v - 1);
            c_hd = (v == 0) ? 4'b0101 : 4'(v - 1);
            @(negedge clk);
            chk("R1 sweep lo", a_lo_o, ((v % 15) * 23) % 15);
            chk("R2 sweep pw", a_pw_o, ((v % 16) * 23) % 16);
            exp_hi(v, 23, 4, ez, ed);
            chk(v == 0 ? "R4 sweep hi flag" : "R3 sweep hi flag", a_hz_o, ez);
            chk(v == 0 ? "R4 sweep hi dim" : "R3 sweep hi dim", a_hd_o, ed);
            chk("R6 multiple lo", c_lo_o, 0);
            chk("R6 reduced pw", c_pw_o, ((v % 16) * 255) % 16);
            chk("R6 multiple hi flag", c_hz_o, 1);
            chk("R6 multiple hi dim", c_hd_o, 0);
        end

        // exhaustive, N=6 MULT=10
        for (int v = 0; v <= 64; v++) begin
            @(posedge clk);
            b_lo = 6'(v % 63); b_pw = 6'(v % 64);
            b_hz = (v == 0);
            b_hd = (v == 0) ? 6'b110011 : 6'(v - 1);
            @(negedge clk);
            chk("R1 wide lo", b_lo_o, ((v % 63) * 10) % 63);
            chk("R2 wide pw", b_pw_o, ((v % 64) * 10) % 64);
            exp_hi(v, 10, 6, ez, ed);
            chk("R3 wide hi flag", b_hz_o, ez);
            chk("R3 wide hi dim", b_hd_o, ed);
        end

        // channel independence: move one input at a time
        @(posedge clk);
        a_lo = 4'd7; a_pw = 4'd8; a_hz = 1'b0; a_hd = 4'd2;
        @(posedge clk);
        a_pw = 4'd3;
        @(negedge clk);
        chk("R5 lo after pw move", a_lo_o, 11);
        chk("R5 hi after pw move", a_hd_o, 0);
        @(posedge clk);
        a_lo = 4'd1;
        @(negedge clk);
        chk("R5 pw after lo move", a_pw_o, (3 * 23) % 16);
        chk("R5 hi flag after lo move", a_hz_o, 0);
        @(posedge clk);
        a_hz = 1'b1;
        @(negedge clk);
        chk("R5 lo after hi move", a_lo_o, 8);
        chk("R5 pw after hi move", a_pw_o, (3 * 23) % 16);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule